// File: doc/BRIEF.md
# Bounded Descending Stack Unit

This block manages a stack that lives in an external single-port memory and grows toward lower addresses. It holds the stack pointer. For each push or pop it drives the memory port, checks the pointer against a fixed floor and ceiling, and reports for every command whether it succeeded. A command that would run past either bound is refused. A refused command leaves the pointer, the memory and the read-data output as they were.

A client raises exactly one of the push or pop strobes for one cycle while the unit is idle. The unit then raises `busy` and works through the memory access. In its last cycle it raises `done` for one cycle, and at that moment `err` carries the outcome. `err` stays at that value until the next command completes. The bottom entry sits at `BASE`, so the pointer value `BASE+1` means the stack is empty. `LIMIT` is the lowest address an entry may occupy. With the default values the stack holds five entries.

The memory port expects a read latency of one cycle. Read data must be valid on `mem_rdata` in the cycle after the one in which `mem_re` is high.

Top module: `bounded_stack`

## Requirements
- R1: After reset, `sp` is `BASE+1` (16'h4000 by default), `err`, `done`, `busy`, `mem_we` and `mem_re` are 0, and `rd_data` is 0.
- R2: An accepted push first lowers `sp` by one and then writes `wr_data` to memory at the new `sp`, with exactly one `mem_we` cycle. It finishes with `err`=0.
- R3: An accepted pop reads memory at the current `sp`, places that word on `rd_data`, and then raises `sp` by one. It finishes with `err`=0.
- R4: A pop issued when `sp` equals `BASE+1` (empty) fails, and `err` is 1 at `done`.
- R5: A push issued when `sp` equals `LIMIT` (full) fails, and `err` is 1 at `done`. With the defaults (`BASE`=16'h3FFF, `LIMIT`=16'h3FFB) the fifth push succeeds and the sixth fails.
- R6: A failed command leaves `sp` unchanged, causes no memory write, and leaves `rd_data` holding its earlier value.
- R7: Push and pop strobes raised in the same cycle are refused with `err`=1, with the effects listed in R6.
- R8: `done` is high for exactly one cycle per command, and `busy` is low in the cycle after `done`. `err` keeps its value from one `done` until the next.
- R9: `sp` never leaves the range from `LIMIT` to `BASE+1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | One-cycle push request, sampled while idle |
| pop | input | 1 | One-cycle pop request, sampled while idle |
| wr_data | input | 16 | Word to push, sampled with the request |
| rd_data | output | 16 | Word returned by the last successful pop |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status of the last command: 0 success, 1 failure |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
The assertions assume that requests arrive only while `busy` is low and that each strobe lasts one cycle. Under those conditions a request seen in an idle cycle maps to a single next state. The bench raises a strobe at a falling edge, drops it at the next falling edge, and does not issue the next request until it has seen `done` and then one idle cycle. Its memory model returns data one cycle after a read enable, which matches the latency the unit expects.

// File: rtl/bounded_stack.sv
module bounded_stack #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE  = 16'h3FFF,
  parameter logic [AW-1:0] LIMIT = 16'h3FFB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sp,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] EMPTY = BASE + 1'b1;

  typedef enum logic [2:0] {IDLE, WR, RD, CAP, FIN} st_t;
  st_t st;
  logic [DW-1:0] data_q;

  wire idle    = (st == IDLE);
  wire both    = idle && push && pop;
  wire push_ok = idle && push && !pop && (sp != LIMIT);
  wire push_nf = idle && push && !pop && (sp == LIMIT);
  wire pop_ok  = idle && pop && !push && (sp != EMPTY);
  wire pop_nf  = idle && pop && !push && (sp == EMPTY);

  assign busy      = !idle;
  assign done      = (st == FIN);
  assign mem_we    = (st == WR);
  assign mem_re    = (st == RD);
  assign mem_addr  = sp;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      sp      <= EMPTY;
      err     <= 1'b0;
      rd_data <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (both || push_nf || pop_nf) begin
            st  <= FIN;
            err <= 1'b1;
          end else if (push_ok) begin
            st     <= WR;
            sp     <= sp - 1'b1;
            data_q <= wr_data;
          end else if (pop_ok) begin
            st <= RD;
          end
        end
        WR: begin
          st  <= FIN;
          err <= 1'b0;
        end
        RD:  st <= CAP;
        CAP: begin
          rd_data <= mem_rdata;
          sp      <= sp + 1'b1;
          err     <= 1'b0;
          st      <= FIN;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R9
  sp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp >= LIMIT) && (sp <= EMPTY));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && push && !pop && sp != LIMIT) |=> (mem_we && sp == $past(sp) - 1'b1));

  // R4
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pop && !push && sp == EMPTY) |=> (done && err));

  // R5
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && push && !pop && sp == LIMIT) |=> (done && err));

  // R7
  dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && push && pop) |=> (done && err));

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(sp) && $stable(rd_data) && !mem_we));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy && $stable(err)));
endmodule

// File: tb/test_bounded_stack.sv
module test_bounded_stack;
  logic clk = 0, rst_n = 0, push = 0, pop = 0;
  logic [15:0] wr_data = '0, rd_data, sp, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic busy, done, err, mem_we, mem_re;
  logic [15:0] mem [8];
  int checks = 0, errors = 0, wcount = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bounded_stack i_bounded_stack (
    .clk, .rst_n, .push, .pop, .wr_data, .rd_data, .sp, .busy, .done, .err,
    .mem_addr, .mem_we, .mem_wdata, .mem_re, .mem_rdata);

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[2:0]] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[2:0]];
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic ps, pp; logic [15:0] din; logic eerr; logic [15:0] erd, esp;
  } vec_t;
  localparam vec_t VEC [16] = '{
    '{1'b0,1'b1,16'h0000,1'b1,16'h0000,16'h4000}, // R4 pop empty
    '{1'b1,1'b0,16'h00A1,1'b0,16'h0000,16'h3FFF}, // R2
    '{1'b1,1'b0,16'h00A2,1'b0,16'h0000,16'h3FFE},
    '{1'b0,1'b1,16'h0000,1'b0,16'h00A2,16'h3FFF}, // R3
    '{1'b1,1'b1,16'h0BAD,1'b1,16'h00A2,16'h3FFF}, // R7
    '{1'b1,1'b0,16'h00B1,1'b0,16'h00A2,16'h3FFE},
    '{1'b1,1'b0,16'h00B2,1'b0,16'h00A2,16'h3FFD},
    '{1'b1,1'b0,16'h00B3,1'b0,16'h00A2,16'h3FFC},
    '{1'b1,1'b0,16'h00B4,1'b0,16'h00A2,16'h3FFB}, // R5 fifth entry
    '{1'b1,1'b0,16'h0BAD,1'b1,16'h00A2,16'h3FFB}, // R5 full
    '{1'b0,1'b1,16'h0000,1'b0,16'h00B4,16'h3FFC}, // R6 entry intact
    '{1'b0,1'b1,16'h0000,1'b0,16'h00B3,16'h3FFD},
    '{1'b0,1'b1,16'h0000,1'b0,16'h00B2,16'h3FFE},
    '{1'b0,1'b1,16'h0000,1'b0,16'h00B1,16'h3FFF},
    '{1'b0,1'b1,16'h0000,1'b0,16'h00A1,16'h4000},
    '{1'b0,1'b1,16'h0000,1'b1,16'h00A1,16'h4000}  // R4 again, R6 held
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp, 16'h4000);
    chk("R1 flags", {11'd0, err, done, busy, mem_we, mem_re}, 16'h0);
    chk("R1 rd_data", rd_data, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      int w0, cyc;
      w0 = wcount;
      push = VEC[i].ps; pop = VEC[i].pp; wr_data = VEC[i].din;
      @(negedge clk);
      push = 0; pop = 0;
      cyc = 0;
      while (!done && cyc < 20) begin @(negedge clk); cyc++; end
      chk($sformatf("R2/R3 done seen vec %0d", i), {15'd0, done}, 16'd1);
      chk($sformatf("R4/R5/R7 err vec %0d", i), {15'd0, err}, {15'd0, VEC[i].eerr});
      chk($sformatf("R3/R6 rd_data vec %0d", i), rd_data, VEC[i].erd);
      chk($sformatf("R2/R3/R9 sp vec %0d", i), sp, VEC[i].esp);
      chk($sformatf("R2/R6 writes vec %0d", i), 16'(wcount - w0),
          (VEC[i].ps && !VEC[i].pp && !VEC[i].eerr) ? 16'd1 : 16'd0);
      if (VEC[i].ps && !VEC[i].pp && !VEC[i].eerr)
        chk($sformatf("R2 stored word vec %0d", i), mem[sp[2:0]], VEC[i].din);
      @(negedge clk);
      // R8 one-cycle done, idle after, err held
      chk($sformatf("R8 done low vec %0d", i), {14'd0, done, busy}, 16'd0);
      chk($sformatf("R8 err held vec %0d", i), {15'd0, err}, {15'd0, VEC[i].eerr});
    end
    // R9 pointer stays in range after the whole run
    chk("R9 sp upper", {15'd0, sp <= 16'h4000}, 16'd1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule